// File: doc/BRIEF.md
# Multi-Select Serial Peripheral Master

This block is the serial side of a single-frame SPI master. A word is offered on a valid/ready handshake. The block then shifts that word out on MOSI while it captures MISO. When the frame is done it presents the received word with a one-cycle strobe. Each frame follows a packed 3-bit mode code, which sets clock polarity, clock phase and bit order. The frame is either 8 or 16 bits long.

Four select lines form a pool. A short request picks one of them as the current target, and each line has its own active level. The block drives the chosen line active for the whole frame and releases it afterwards, so software never has to toggle it. The serial clock comes from an integer divider of the system clock. A new divider value can be written between frames.

Top module: `spim_top`

## Requirements
- R1: Mode code bits: bit 0 set sends and receives LSB first, bit 1 set selects CPHA=1, bit 2 set selects CPOL=1. While idle, SCLK rests at the CPOL level of the current mode code, and it is back at that level when the frame ends.
- R2: With CPHA=0, the first data bit is on MOSI before the first SCLK edge. MISO is sampled on leading edges and MOSI changes on trailing edges. With CPHA=1, MOSI changes on leading edges and MISO is sampled on trailing edges. The word seen on MOSI equals tx_data, and rx_data equals the word presented on MISO, both in the bit order that R1 selects.
- R3: A frame length code of 16 gives 16-bit frames (32 SCLK edges). Any other code gives 8-bit frames (16 SCLK edges), using the low 8 bits of tx_data, with rx_data[15:8] returned as zero.
- R4: Every SCLK half period, including the setup time from select assertion to the first edge, lasts cfg_div+1 system clocks. cfg_div is captured when a word is accepted, and later changes do not affect the frame in flight.
- R5: Each select line has a polarity bit, where 0 means active low and 1 means active high. All polarity bits are 0 after reset. A pulse on pol_we while idle loads pol_data; while busy it is ignored. A line that is not active is held at the inverse of its polarity bit.
- R6: The current line goes to its active level in the same clock edge that accepts a word. It returns to its inactive level in the edge where busy falls. No more than one line is active at any time.
- R7: Line 0 is the current line after reset. A sel_req while idle makes sel_idx the current line and raises no error. A sel_req while busy leaves the current line unchanged, and sel_err is high for exactly the next cycle.
- R8: tx_ready equals not busy. A word is accepted when tx_valid and tx_ready are both high. busy rises in the accepting edge and falls in the edge that releases the select line. In that same edge rx_valid rises for one cycle, and rx_data holds the received word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 3 | Mode code: bit 2 CPOL, bit 1 CPHA, bit 0 LSB first |
| cfg_bits | input | 5 | Frame length code, 16 or anything else (8) |
| cfg_div | input | 8 | Half period minus one, in system clocks |
| pol_we | input | 1 | Load select polarity bits (idle only) |
| pol_data | input | 4 | New polarity bits, 1 = active high |
| sel_req | input | 1 | Request to change the current select line |
| sel_idx | input | 2 | Requested select line |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Block can accept a word |
| tx_data | input | 16 | Transmit word |
| rx_valid | output | 1 | One-cycle strobe, received word ready |
| rx_data | output | 16 | Received word |
| busy_o | output | 1 | Frame in progress |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_o | output | 4 | Select lines |
| sel_err | output | 1 | Refused select change, one-cycle pulse |

## Verification
The bench runs a slave model that follows SCLK in every one of the eight mode codes. It checks the exact word in both directions. A swapped phase or a reversed bit order would show up as rotated or mirrored words, and a mis-decoded polarity would leave SCLK at the wrong rest level. Frame length codes of 12 and 0 must still give 16 edges; a design that passed the code through would clock extra bits. The bench also times every half period while cfg_div changes mid-frame, because a divider that is not captured would stretch or shrink edges. It issues a line change and a polarity write during a frame. A design that obeyed either one would drop the current line, glitch its level, or move the next frame to another slave, and the bench would see it.

// File: rtl/spim_pkg.sv
package spim_pkg;

  typedef struct packed {
    logic cpol;
    logic cpha;
    logic lsb;
  } spim_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_TRAIL = 2'd2
  } spim_state_t;

  function automatic spim_mode_t decode_mode(input logic [2:0] code);
    spim_mode_t m;
    m.cpol = code[2];
    m.cpha = code[1];
    m.lsb  = code[0];
    return m;
  endfunction

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  // one tick every div+1 cycles while running; counter parked at zero otherwise
  assign tick = run && (cnt_q == div);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [WORD_W-1:0]         load_data,
  input  logic                      cfg_lsb,
  input  logic [$clog2(WORD_W):0]   cfg_nbits,
  input  logic                      launch,
  input  logic [$clog2(WORD_W)-1:0] launch_idx,
  input  logic                      sample,
  input  logic [$clog2(WORD_W)-1:0] sample_idx,
  input  logic                      miso_i,
  output logic                      mosi_o,
  output logic [WORD_W-1:0]         rx_word
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam int NB_W  = IDX_W + 1;

  logic [WORD_W-1:0] tx_q;
  logic [WORD_W-1:0] rx_q;
  logic              lsb_q;
  logic [NB_W-1:0]   nb_q;

  // maps the serial position of a bit to its index in the word
  function automatic logic [IDX_W-1:0] wire_pos(input logic lsb,
                                                input logic [NB_W-1:0] nb,
                                                input logic [IDX_W-1:0] i);
    logic [NB_W-1:0] rev;
    rev = nb - NB_W'(1) - NB_W'(i);
    return lsb ? i : rev[IDX_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      rx_q   <= '0;
      lsb_q  <= 1'b0;
      nb_q   <= '0;
      mosi_o <= 1'b0;
    end else if (load) begin
      tx_q   <= load_data;
      rx_q   <= '0;
      lsb_q  <= cfg_lsb;
      nb_q   <= cfg_nbits;
      mosi_o <= load_data[wire_pos(cfg_lsb, cfg_nbits, '0)];
    end else begin
      if (launch) mosi_o <= tx_q[wire_pos(lsb_q, nb_q, launch_idx)];
      if (sample) rx_q[wire_pos(lsb_q, nb_q, sample_idx)] <= miso_i;
    end
  end

  assign rx_word = rx_q;

endmodule

// File: rtl/spim_selmux.sv
module spim_selmux #(
  parameter int NSEL = 4
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     sel_req,
  input  logic [((NSEL > 1) ? $clog2(NSEL) : 1)-1:0] sel_idx,
  input  logic                                     pol_we,
  input  logic [NSEL-1:0]                          pol_data,
  input  logic                                     busy,
  input  logic                                     hold_sel,
  output logic [NSEL-1:0]                          ss_o,
  output logic [NSEL-1:0]                          pol_o,
  output logic                                     sel_err
);

  localparam int SIDX_W = (NSEL > 1) ? $clog2(NSEL) : 1;

  logic [NSEL-1:0]   pol_q, pol_n, ss_n;
  logic [SIDX_W-1:0] act_q, act_n;

  always_comb begin
    pol_n = (pol_we && !busy)  ? pol_data : pol_q;
    act_n = (sel_req && !busy) ? sel_idx  : act_q;
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_line
    assign ss_n[g] = (hold_sel && (act_n == SIDX_W'(g))) ? pol_n[g] : ~pol_n[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pol_q   <= '0;
      act_q   <= '0;
      ss_o    <= '1;
      sel_err <= 1'b0;
    end else begin
      pol_q   <= pol_n;
      act_q   <= act_n;
      ss_o    <= ss_n;
      sel_err <= sel_req && busy;
    end
  end

  assign pol_o = pol_q;

endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int SHORT_BITS = 8,
  parameter int LONG_BITS  = 16,
  parameter int DIV_W      = 8,
  parameter int NSEL       = 4
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic [2:0]                               cfg_mode,
  input  logic [$clog2(LONG_BITS):0]               cfg_bits,
  input  logic [DIV_W-1:0]                         cfg_div,
  input  logic                                     pol_we,
  input  logic [NSEL-1:0]                          pol_data,
  input  logic                                     sel_req,
  input  logic [((NSEL > 1) ? $clog2(NSEL) : 1)-1:0] sel_idx,
  input  logic                                     tx_valid,
  output logic                                     tx_ready,
  input  logic [LONG_BITS-1:0]                     tx_data,
  output logic                                     rx_valid,
  output logic [LONG_BITS-1:0]                     rx_data,
  output logic                                     busy_o,
  output logic                                     sclk_o,
  output logic                                     mosi_o,
  input  logic                                     miso_i,
  output logic [NSEL-1:0]                          ss_o,
  output logic                                     sel_err
);

  localparam int IDX_W  = $clog2(LONG_BITS);
  localparam int BITS_W = IDX_W + 1;
  localparam int EDGE_W = IDX_W + 1;

  spim_state_t          state_q;
  logic                 busy_q;
  logic                 sclk_q;
  logic                 cpha_q;
  logic [DIV_W-1:0]     div_q;
  logic [BITS_W-1:0]    nb_q;
  logic [EDGE_W-1:0]    edge_q;
  logic                 rx_valid_q;
  logic [LONG_BITS-1:0] rx_data_q;

  spim_mode_t           mode_in;
  logic [BITS_W-1:0]    nb_in;
  logic                 tick, accept, edge_ev, last_edge, lead_edge;
  logic                 do_sample, do_launch, hold_sel;
  logic [IDX_W-1:0]     bit_idx, launch_idx;
  logic [LONG_BITS-1:0] rx_word;
  logic [NSEL-1:0]      pol_w;

  assign mode_in   = decode_mode(cfg_mode);
  assign nb_in     = (cfg_bits == BITS_W'(LONG_BITS)) ? BITS_W'(LONG_BITS) : BITS_W'(SHORT_BITS);
  assign accept    = tx_valid && !busy_q;
  assign edge_ev   = tick && (state_q == ST_SHIFT);
  assign last_edge = (edge_q == EDGE_W'(2 * nb_q - 1));
  assign lead_edge = ~edge_q[0];
  assign bit_idx   = edge_q[EDGE_W-1:1];

  // phase 0: sample on leading, shift on trailing (no shift after the final edge)
  // phase 1: shift on leading, sample on trailing
  assign do_sample  = edge_ev && (cpha_q ? ~lead_edge : lead_edge);
  assign do_launch  = edge_ev && (cpha_q ? lead_edge : (~lead_edge && !last_edge));
  assign launch_idx = cpha_q ? bit_idx : bit_idx + IDX_W'(1);

  // select held from the accepting edge until the trailing half period ends
  assign hold_sel = accept || (busy_q && !((state_q == ST_TRAIL) && tick));

  spim_clkdiv #(.DIV_W(DIV_W)) u_clkdiv (
    .clk  (clk),
    .rst  (rst),
    .run  (busy_q),
    .div  (div_q),
    .tick (tick)
  );

  spim_shifter #(.WORD_W(LONG_BITS)) u_shifter (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .load_data  (tx_data),
    .cfg_lsb    (mode_in.lsb),
    .cfg_nbits  (nb_in),
    .launch     (do_launch),
    .launch_idx (launch_idx),
    .sample     (do_sample),
    .sample_idx (bit_idx),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .rx_word    (rx_word)
  );

  spim_selmux #(.NSEL(NSEL)) u_selmux (
    .clk      (clk),
    .rst      (rst),
    .sel_req  (sel_req),
    .sel_idx  (sel_idx),
    .pol_we   (pol_we),
    .pol_data (pol_data),
    .busy     (busy_q),
    .hold_sel (hold_sel),
    .ss_o     (ss_o),
    .pol_o    (pol_w),
    .sel_err  (sel_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      busy_q     <= 1'b0;
      sclk_q     <= 1'b0;
      cpha_q     <= 1'b0;
      div_q      <= '0;
      nb_q       <= BITS_W'(SHORT_BITS);
      edge_q     <= '0;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          sclk_q <= mode_in.cpol;
          if (accept) begin
            state_q <= ST_SHIFT;
            busy_q  <= 1'b1;
            cpha_q  <= mode_in.cpha;
            div_q   <= cfg_div;
            nb_q    <= nb_in;
            edge_q  <= '0;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            sclk_q <= ~sclk_q;
            edge_q <= edge_q + 1'b1;
            if (last_edge) state_q <= ST_TRAIL;
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            state_q    <= ST_IDLE;
            busy_q     <= 1'b0;
            rx_valid_q <= 1'b1;
            rx_data_q  <= rx_word;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tx_ready = !busy_q;
  assign busy_o   = busy_q;
  assign sclk_o   = sclk_q;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;

endmodule

// File: rtl/spim_top_chk.sv
module spim_top_chk #(
  parameter int NSEL  = 4,
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       cfg_mode,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             sel_req,
  input logic             sel_err,
  input logic             pol_we,
  input logic             rx_valid,
  input logic             busy_o,
  input logic             sclk_o,
  input logic [NSEL-1:0]  ss_o,
  input logic [NSEL-1:0]  pol,
  input logic [DIV_W-1:0] div_q
);

  logic           sclk_d, busy_d;
  logic [DIV_W:0] run_q;

  // cycles since the previous SCLK change (or since the frame began)
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      busy_d <= 1'b0;
      run_q  <= '0;
    end else begin
      sclk_d <= sclk_o;
      busy_d <= busy_o;
      if (!busy_o)                         run_q <= '0;
      else if (busy_d && sclk_o != sclk_d) run_q <= (DIV_W+1)'(1);
      else                                 run_q <= run_q + 1'b1;
    end
  end

  p_idle_rest_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |=> (sclk_o == $past(cfg_mode[2])));

  p_half_period_r4: assert property (@(posedge clk) disable iff (rst)
    (busy_o && busy_d && (sclk_o != sclk_d)) |-> (run_q == ((DIV_W+1)'(div_q) + 1'b1)));

  p_pol_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (pol_we && busy_o) |=> $stable(pol));

  p_single_line_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~(ss_o ^ pol)));

  p_refuse_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_req && busy_o) |=> sel_err);

  p_accept_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (sel_req && !busy_o) |=> !sel_err);

  p_line_needs_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (~(ss_o ^ pol) != '0) |-> busy_o);

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> busy_o);

  p_rx_at_end_r8: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (!busy_o && $past(busy_o)));

endmodule

bind spim_top spim_top_chk #(.NSEL(NSEL), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_mode (cfg_mode),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .sel_req  (sel_req),
  .sel_err  (sel_err),
  .pol_we   (pol_we),
  .rx_valid (rx_valid),
  .busy_o   (busy_o),
  .sclk_o   (sclk_o),
  .ss_o     (ss_o),
  .pol      (pol_w),
  .div_q    (div_q)
);

// File: tb/spim_top_bench.sv
module spim_top_bench;

  localparam int NSEL  = 4;
  localparam int DIV_W = 8;
  localparam int WORD  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0]       cfg_mode = '0;
  logic [4:0]       cfg_bits = 5'd8;
  logic [DIV_W-1:0] cfg_div  = '0;
  logic             pol_we   = 1'b0;
  logic [NSEL-1:0]  pol_data = '0;
  logic             sel_req  = 1'b0;
  logic [1:0]       sel_idx  = '0;
  logic             tx_valid = 1'b0;
  logic [WORD-1:0]  tx_data  = '0;
  logic             tx_ready, rx_valid, busy, sclk, mosi, sel_err;
  logic             miso = 1'b0;
  logic [WORD-1:0]  rx_data;
  logic [NSEL-1:0]  ss;

  spim_top u_spim_top (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_bits(cfg_bits), .cfg_div(cfg_div),
    .pol_we(pol_we), .pol_data(pol_data), .sel_req(sel_req), .sel_idx(sel_idx),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .busy_o(busy), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso), .ss_o(ss), .sel_err(sel_err)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // slave model expectations
  logic            exp_cpha = 1'b0;
  logic            exp_lsb  = 1'b0;
  int              exp_n    = 8;
  int              exp_line = 0;
  logic [NSEL-1:0] exp_pol  = '0;
  logic [WORD-1:0] slave_word = '0;
  logic [WORD-1:0] got_mosi   = '0;
  int              edge_cnt = 0;
  int              iv = 0, iv_min = 0, iv_max = 0;
  logic            prev_sclk = 1'b0;
  logic            prev_act  = 1'b0;

  function automatic int bpos(input logic lsb, input int n, input int i);
    return lsb ? i : n - 1 - i;
  endfunction

  // slave: follows SCLK seen away from the active edge
  always @(negedge clk) begin
    logic act;
    int   k;
    act = (ss[exp_line] == exp_pol[exp_line]);
    iv  = iv + 1;
    if (act && !prev_act) begin
      edge_cnt = 0;
      got_mosi = '0;
      iv       = 0;
      iv_min   = 1000000;
      iv_max   = 0;
      if (!exp_cpha) miso = slave_word[bpos(exp_lsb, exp_n, 0)];
    end else if (act && (sclk != prev_sclk)) begin
      k = edge_cnt;
      if (iv < iv_min) iv_min = iv;
      if (iv > iv_max) iv_max = iv;
      iv = 0;
      if (((k % 2) == 0) != exp_cpha) begin
        if (k / 2 < exp_n) got_mosi[bpos(exp_lsb, exp_n, k / 2)] = mosi;
      end else begin
        int nb;
        nb = exp_cpha ? k / 2 : k / 2 + 1;
        if (nb < exp_n) miso = slave_word[bpos(exp_lsb, exp_n, nb)];
      end
      edge_cnt = edge_cnt + 1;
    end
    prev_act  = act;
    prev_sclk = sclk;
  end

  task automatic chk(input string req, input string what, input logic [31:0] actual, input logic [31:0] expected);
    n_chk++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
    end
  endtask

  task automatic xfer(input logic [2:0] mode, input logic [4:0] bits, input logic [7:0] div,
                      input logic [15:0] data, input logic [15:0] sword, input bit poke,
                      input logic [7:0] div_late);
    int              n, guard;
    logic [15:0]     mask;
    logic [NSEL-1:0] idle_vec, act_vec;
    n        = (bits == 5'd16) ? 16 : 8;
    mask     = (n == 16) ? 16'hFFFF : 16'h00FF;
    exp_cpha = mode[1];
    exp_lsb  = mode[0];
    exp_n    = n;
    slave_word = sword;
    idle_vec = ~exp_pol;
    act_vec  = idle_vec ^ (NSEL'(1) << exp_line);
    @(negedge clk);
    chk("R8", "tx_ready idle", 32'(tx_ready), 32'd1);
    cfg_mode = mode; cfg_bits = bits; cfg_div = div; tx_data = data; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    cfg_div  = div_late;
    chk("R8", "busy after accept", 32'(busy), 32'd1);
    chk("R6", "select asserted", 32'(ss), 32'(act_vec));
    chk("R1", "sclk rest level", 32'(sclk), 32'(mode[2]));
    if (poke) begin
      sel_req = 1'b1; sel_idx = 2'(exp_line) ^ 2'd1;
      pol_we  = 1'b1; pol_data = ~exp_pol;
      @(negedge clk);
      sel_req = 1'b0; pol_we = 1'b0;
      chk("R7", "sel_err on busy change", 32'(sel_err), 32'd1);
      chk("R6", "line kept during refused change", 32'(ss), 32'(act_vec));
    end
    guard = 0;
    while (!rx_valid && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk("R8", "rx_valid seen", 32'(rx_valid), 32'd1);
    chk("R2", "received word", 32'(rx_data), 32'(sword & mask));
    chk("R2", "word on mosi", 32'(got_mosi), 32'(data & mask));
    chk("R3", "edge count", 32'(edge_cnt), 32'(2 * n));
    chk("R4", "min half period", 32'(iv_min), 32'(div) + 1);
    chk("R4", "max half period", 32'(iv_max), 32'(div) + 1);
    chk("R8", "busy low at strobe", 32'(busy), 32'd0);
    chk("R6", "select released", 32'(ss), 32'(idle_vec));
    chk("R1", "sclk back at rest", 32'(sclk), 32'(mode[2]));
    @(negedge clk);
    chk("R8", "rx_valid single cycle", 32'(rx_valid), 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R5", "select lines after reset", 32'(ss), 32'hF);
    chk("R8", "busy after reset", 32'(busy), 32'd0);
    chk("R8", "tx_ready after reset", 32'(tx_ready), 32'd1);
    chk("R8", "rx_valid after reset", 32'(rx_valid), 32'd0);
    chk("R7", "sel_err after reset", 32'(sel_err), 32'd0);
    chk("R1", "sclk after reset", 32'(sclk), 32'd0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 8; m++) begin
      xfer(3'(m), 5'd8, 8'd1, 16'h5AC3 + 16'(m * 16'h0111), 16'h3C96 ^ 16'(m * 16'h0025), 1'b0, 8'd1);
    end
  endtask

  task automatic t_wide();
    xfer(3'd0, 5'd16, 8'd0, 16'hBEEF, 16'h1234, 1'b0, 8'd0);
    xfer(3'd7, 5'd16, 8'd2, 16'h8001, 16'h7FFE, 1'b0, 8'd2);
    xfer(3'd5, 5'd16, 8'd0, 16'hC0DE, 16'hF00D, 1'b0, 8'd0);
  endtask

  task automatic t_badlen();
    // R3: codes other than 16 fall back to 8 bits
    xfer(3'd2, 5'd12, 8'd0, 16'hFFA6, 16'hFF59, 1'b0, 8'd0);
    xfer(3'd1, 5'd0,  8'd1, 16'h1281, 16'hEE7E, 1'b0, 8'd1);
  endtask

  task automatic t_div();
    xfer(3'd0, 5'd8, 8'd3, 16'h0096, 16'h0069, 1'b0, 8'd3);
    // R4: divider change after acceptance must not alter the frame
    xfer(3'd6, 5'd8, 8'd5, 16'h00E1, 16'h001E, 1'b0, 8'd0);
  endtask

  task automatic t_pol();
    @(negedge clk);
    pol_we = 1'b1; pol_data = 4'b0100;
    sel_req = 1'b1; sel_idx = 2'd2;
    @(negedge clk);
    pol_we = 1'b0; sel_req = 1'b0;
    chk("R5", "idle levels after polarity load", 32'(ss), 32'hB);
    chk("R7", "no error on idle change", 32'(sel_err), 32'd0);
    exp_pol  = 4'b0100;
    exp_line = 2;
    xfer(3'd3, 5'd8, 8'd1, 16'h004D, 16'h00B2, 1'b0, 8'd1);
  endtask

  task automatic t_refuse();
    // R5/R7: polarity write and line change while busy are refused
    xfer(3'd4, 5'd8, 8'd2, 16'h0071, 16'h008E, 1'b1, 8'd2);
    @(negedge clk);
    chk("R5", "polarity unchanged after busy write", 32'(ss), 32'hB);
    xfer(3'd0, 5'd8, 8'd0, 16'h0033, 16'h00CC, 1'b0, 8'd0);
  endtask

  task automatic t_restore();
    @(negedge clk);
    pol_we = 1'b1; pol_data = 4'b0000;
    sel_req = 1'b1; sel_idx = 2'd0;
    @(negedge clk);
    pol_we = 1'b0; sel_req = 1'b0;
    exp_pol  = '0;
    exp_line = 0;
    chk("R5", "all lines idle high", 32'(ss), 32'hF);
    xfer(3'd0, 5'd8, 8'd0, 16'h00A5, 16'h005A, 1'b0, 8'd0);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    xfer(3'd0, 5'd8, 8'd0, 16'h00A7, 16'h0053, 1'b0, 8'd0); // R7: line 0 is the default target
    t_modes();
    t_wide();
    t_badlen();
    t_div();
    t_pol();
    t_refuse();
    t_restore();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule